// File: doc/BRIEF.md
# Snapshot-Read 64-bit Tick Counter

This block keeps a free-running count of input ticks, twice the register word wide (64 bits at the default 32-bit word). Software cannot see the running count directly. It asks for a coherent snapshot instead. A write to the command register with the capture bit set copies the whole count into the two visible word registers in one clock edge. Software can then read the low and high halves at leisure, and the two halves always belong together.

A second command bit zeroes both the visible words and the running count. Both command bits act once and are never kept in the stored command value. The visible words can also be written directly as scratch storage; such a write leaves the running count alone. The register port is a plain single-cycle write strobe with a word select and a combinational read-data path. There is no flow control.

Top module: `snapcnt_top`

## Requirements
- R1: After reset, the command register (select 0), the low word (select 1) and the high word (select 2) all read zero, and the running count is zero.
- R2: The running count increases by exactly one on each clock edge where `tick_i` is high, and holds on every other edge.
- R3: A write to select 0 with bit 1 (capture) set loads {high, low} with the running count as it stood before that edge, including when a tick arrives in the same cycle. The two halves are taken on one edge.
- R4: A write to select 0 with bit 0 (clear) set zeroes the low word, the high word and the running count. A tick in the same cycle is dropped, and counting resumes from zero afterwards.
- R5: When bits 1 and 0 are both set in one write, the capture is overridden by the clear, so both words and the running count end at zero.
- R6: The command register stores the written value with bits 1 and 0 forced to zero. Its other bits read back exactly as written.
- R7: Writes to select 1 and select 2 replace the low and high word respectively and do not change the running count.
- R8: Select 3 reads zero, and a write to it changes no register.
- R9: The carry from the low half of the count propagates into the high half.
- R10: The count wraps from all ones to zero on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one increment per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 command, 1 low word, 2 high word, 3 reserved |
| wdata_i | input | WORD_W | Write data |
| rdata_o | output | WORD_W | Read data for `addr_i`, combinational |

## Verification
Every register effect of a write (capture, clear, direct load, command store) is due on the rising edge that samples the strobe, and the count moves on that same edge. Read data follows `addr_i` with no cycle of delay. The bench drives strobes and ticks on the falling edge and removes them on the next falling edge, so exactly one rising edge sees them. It then selects a register and samples 1 ns later, well clear of either edge. The bench runs the block with an 8-bit word so that the carry into the high half and the full wrap can be reached within a short run.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  localparam int CMD_CLEAR_BIT   = 0;
  localparam int CMD_CAPTURE_BIT = 1;
endpackage

// File: rtl/snapcnt_run.sv
module snapcnt_run #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (clear_i) count_o <= '0;
    else if (tick_i)  count_o <= count_o + 1'b1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clear_i) |=> count_o == $past(count_o) + 1'b1);

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(count_o));

  // R4
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0);
endmodule

// File: rtl/snapcnt_regs.sv
module snapcnt_regs
  import snapcnt_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              clear_o,
  output logic [WORD_W-1:0] lo_o,
  output logic [WORD_W-1:0] hi_o,
  output logic [WORD_W-1:0] cmd_o
);
  logic              sel_cmd, sel_lo, sel_hi, sel_rsvd;
  logic              capture_cmd, clear_cmd;
  logic [WORD_W-1:0] cmd_keep_mask;

  assign sel_cmd  = wr_en_i && (addr_i == SEL_CMD);
  assign sel_lo   = wr_en_i && (addr_i == SEL_LO);
  assign sel_hi   = wr_en_i && (addr_i == SEL_HI);
  assign sel_rsvd = wr_en_i && (addr_i == SEL_RSVD);

  assign capture_cmd = sel_cmd && wdata_i[CMD_CAPTURE_BIT];
  assign clear_cmd   = sel_cmd && wdata_i[CMD_CLEAR_BIT];
  assign clear_o     = clear_cmd;

  always_comb begin
    cmd_keep_mask = '1;
    cmd_keep_mask[CMD_CAPTURE_BIT] = 1'b0;
    cmd_keep_mask[CMD_CLEAR_BIT]   = 1'b0;
  end

  // clear has the last word over capture in the same write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (clear_cmd) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (capture_cmd) begin
      {hi_o, lo_o} <= count_i;
    end else begin
      if (sel_lo) lo_o <= wdata_i;
      if (sel_hi) hi_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cmd_o <= '0;
    else if (sel_cmd) cmd_o <= wdata_i & cmd_keep_mask;
  end

  // R3
  snap_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_cmd && !clear_cmd) |=> {hi_o, lo_o} == $past(count_i));

  // R5
  snap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_cmd |=> (lo_o == '0) && (hi_o == '0));

  // R7
  lo_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_lo |=> lo_o == $past(wdata_i));

  // R8
  rsvd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rsvd |=> $stable(lo_o) && $stable(hi_o) && $stable(cmd_o));
endmodule

// File: rtl/snapcnt_rdmux.sv
module snapcnt_rdmux
  import snapcnt_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] cmd_i,
  output logic [WORD_W-1:0] rdata_o
);
  always_comb begin
    unique case (addr_i)
      SEL_CMD: rdata_o = cmd_i;
      SEL_LO:  rdata_o = lo_i;
      SEL_HI:  rdata_o = hi_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top #(
  parameter int WORD_W = 32,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [CNT_W-1:0]  count;
  logic              clear;
  logic [WORD_W-1:0] lo, hi, cmd;

  snapcnt_run #(.CNT_W(CNT_W)) u_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clear_i (clear),
    .count_o (count)
  );

  snapcnt_regs #(.WORD_W(WORD_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .count_i (count),
    .clear_o (clear),
    .lo_o    (lo),
    .hi_o    (hi),
    .cmd_o   (cmd)
  );

  snapcnt_rdmux #(.WORD_W(WORD_W)) u_rdmux (
    .addr_i  (addr_i),
    .lo_i    (lo),
    .hi_i    (hi),
    .cmd_i   (cmd),
    .rdata_o (rdata_o)
  );
endmodule

// File: tb/snapcnt_top_tb.sv
module snapcnt_top_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  snapcnt_top #(.WORD_W(W)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input logic tk);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic snap_check(input string req, input logic [W-1:0] exp_hi, input logic [W-1:0] exp_lo);
    logic [W-1:0] v;
    wr(2'd0, 8'h02, 1'b0);
    rd(2'd1, v); chk(req, v, exp_lo);
    rd(2'd2, v); chk(req, v, exp_hi);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(2'd0, v); chk("R1 cmd", v, 8'h00);
    rd(2'd1, v); chk("R1 lo", v, 8'h00);
    rd(2'd2, v); chk("R1 hi", v, 8'h00);
    snap_check("R1 count", 8'h00, 8'h00);
  endtask

  task automatic t_count();
    ticks(5);
    repeat (3) @(negedge clk);
    snap_check("R2 five ticks", 8'h00, 8'h05);
  endtask

  task automatic t_capture_with_tick();
    logic [W-1:0] v;
    wr(2'd0, 8'h02, 1'b1);
    rd(2'd1, v); chk("R3 pre-edge count", v, 8'h05);
    snap_check("R2 tick during capture", 8'h00, 8'h06);
  endtask

  task automatic t_carry();
    ticks(294);
    snap_check("R9 carry 0x012C", 8'h01, 8'h2C);
  endtask

  task automatic t_direct();
    logic [W-1:0] v;
    wr(2'd1, 8'h55, 1'b0);
    wr(2'd2, 8'hAA, 1'b0);
    rd(2'd1, v); chk("R7 lo write", v, 8'h55);
    rd(2'd2, v); chk("R7 hi write", v, 8'hAA);
    snap_check("R7 count untouched", 8'h01, 8'h2C);
  endtask

  task automatic t_clear();
    logic [W-1:0] v;
    wr(2'd0, 8'h01, 1'b1);
    rd(2'd1, v); chk("R4 lo", v, 8'h00);
    rd(2'd2, v); chk("R4 hi", v, 8'h00);
    rd(2'd0, v); chk("R4 cmd bit clear", v, 8'h00);
    ticks(3);
    snap_check("R4 restart", 8'h00, 8'h03);
  endtask

  task automatic t_both();
    logic [W-1:0] v;
    ticks(4);
    wr(2'd1, 8'h11, 1'b0);
    wr(2'd0, 8'h03, 1'b0);
    rd(2'd1, v); chk("R5 lo", v, 8'h00);
    rd(2'd2, v); chk("R5 hi", v, 8'h00);
    snap_check("R5 count zero", 8'h00, 8'h00);
  endtask

  task automatic t_cmd_store();
    logic [W-1:0] v;
    wr(2'd0, 8'hFC, 1'b0);
    rd(2'd0, v); chk("R6 plain bits", v, 8'hFC);
    rd(2'd1, v); chk("R6 no capture", v, 8'h00);
    wr(2'd0, 8'hF3, 1'b0);
    rd(2'd0, v); chk("R6 cmd bits dropped", v, 8'hF0);
  endtask

  task automatic t_rsvd();
    logic [W-1:0] v;
    wr(2'd1, 8'h33, 1'b0);
    wr(2'd3, 8'hFF, 1'b0);
    rd(2'd3, v); chk("R8 read zero", v, 8'h00);
    rd(2'd1, v); chk("R8 lo kept", v, 8'h33);
    rd(2'd2, v); chk("R8 hi kept", v, 8'h00);
    rd(2'd0, v); chk("R8 cmd kept", v, 8'hF0);
  endtask

  task automatic t_wrap();
    wr(2'd0, 8'h01, 1'b0);
    ticks(65535);
    snap_check("R10 all ones", 8'hFF, 8'hFF);
    ticks(1);
    snap_check("R10 wrap", 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_capture_with_tick();
    t_carry();
    t_direct();
    t_clear();
    t_both();
    t_cmd_store();
    t_rsvd();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule